// File: doc/BRIEF.md
# Windowed Data-ROM Read Port

This block gives a host CPU a byte-wide window into a data ROM. The host loads a 24-bit pointer, a 16-bit adjust value and a 16-bit step value through an 8-bit register bus. It then reads bytes through one of two data ports. The plain data port fetches at the pointer, or at pointer plus adjust, and then advances either the pointer or the adjust register. The adjusted data port always fetches at pointer plus adjust, and it moves state only in one particular mode. A mode register chooses signed or unsigned arithmetic, the increment source and the increment target. In certain modes, writing the adjust bytes moves the pointer at once.

Every reduction modulo the ROM size (`rom_size`) runs in a shared sequential compare-and-subtract unit, which takes 24 cycles per reduction. While a port read or an immediate update is in progress, the controller holds `hb_ready` low.

The controller has five states:
- `ST_IDLE` serves register accesses.
- `ST_IMM_MOD` reduces the pointer after an immediate update.
- `ST_RD_AMOD` reduces the fetch address.
- `ST_RD_PMOD` reduces the new pointer.
- `ST_RD_WAIT` holds the ROM request until the byte returns.

The transitions are:
- `ST_IDLE` to `ST_RD_AMOD` on an accepted port read.
- `ST_IDLE` to `ST_IMM_MOD` when an adjust write fires an immediate update.
- `ST_IMM_MOD` to `ST_IDLE` when the reduction is done.
- `ST_RD_AMOD` to `ST_RD_PMOD` when the reduction is done and the read rewrites the pointer, otherwise to `ST_RD_WAIT`.
- `ST_RD_PMOD` to `ST_RD_WAIT` when the reduction is done.
- `ST_RD_WAIT` to `ST_IDLE` on `rom_valid`.

Top module: `romport_top`

## Requirements
- R1: After reset, every register reads 0, `hb_ready` is high in idle and `rom_req` is low. Register offsets on `hb_addr`: 0 plain port, 1 adjusted port, 2/3/4 pointer low/middle/high, 5/6 adjust low/high, 7/8 step low/high, 9 mode. Other offsets read 0.
- R2: Each write to a pointer byte or an adjust byte sets its own bit in a five-bit written mask. A plain-port read returns 0 in the same cycle, without a ROM request, unless all three pointer bytes have been written. An adjusted-port read does the same unless all five have been written.
- R3: A mode write takes effect only when both adjust bytes have been written. An accepted mode write clears the immediate-update tracker.
- R4: A plain-port read fetches at BASE (0x100000) + ((pointer + A) mod 2^24) mod `rom_size`. A is the adjust value when mode bit 1 is set and 0 otherwise. The adjust is treated as two's complement when mode bit 3 is set and as unsigned otherwise.
- R5: A plain-port read with mode bit 1 set increments the adjust register by 1, wrapping at 16 bits, and leaves the pointer value unchanged.
- R6: A plain-port read with mode bit 1 clear uses an increment equal to the step register when mode bit 0 is set (signed when mode bit 2 is set) and 1 otherwise. The increment goes to the pointer when mode bit 4 is clear, and to the adjust register (low 16 bits) when mode bit 4 is set.
- R7: Every plain-port read stores the pointer back reduced modulo `rom_size`, taken after a 2^24 wrap.
- R8: An adjusted-port read fetches at pointer plus adjust, reduced as in R4. State changes only when mode bits 5 and 6 are both set. Then the pointer becomes the reduced pointer plus adjust if mode bit 4 is clear, or the adjust doubles (16-bit wrap) if mode bit 4 is set.
- R9: The immediate update requires mode bit 1 set and exactly one of mode bits 5 and 6 set. Under those conditions each adjust-byte write sets its tracker bit. Once both bits are set and mode bit 4 is clear, the pointer becomes (pointer + amount) reduced. The amount is the low adjust byte (sign-extended when bit 3 is set) for bit 5, or the full adjust for bit 6.
- R10: While a port read or an immediate update is in progress, `hb_ready` is low. `rom_req` stays high with a stable address until `rom_valid`. The byte appears on `hb_rdata` and the pointer and adjust updates commit in the `rom_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_size | input | 24 | Data ROM size in bytes (nonzero) |
| hb_sel | input | 1 | Host access strobe, held until ready |
| hb_we | input | 1 | Host write when high |
| hb_addr | input | 4 | Host register offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data |
| hb_ready | output | 1 | Access completes at the clock edge where this is high |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 25 | ROM byte address |
| rom_valid | input | 1 | ROM data valid, one cycle per request |
| rom_data | input | 8 | ROM read data |

## Verification
The assertions take for granted the following about the inputs:
- `rom_size` is nonzero and does not change while a read is in flight.
- The host keeps `hb_sel`, `hb_we` and `hb_addr` steady until `hb_ready`.
- `rom_valid` arrives only in answer to an active `rom_req`.

The stimulus meets these conditions in three ways. It changes the size only between transactions, while idle. It drives a handshaking host task that waits for ready. It answers with a ROM responder that raises valid once, a few cycles after it sees a request.

// File: rtl/romport_pkg.sv
`timescale 1ns/1ps
package romport_pkg;
    parameter int PTR_W  = 24;
    parameter int ADJ_W  = 16;
    parameter int DAT_W  = 8;
    parameter int HA_W   = 4;
    localparam int MASK_W = 5;

    localparam int MB_USESTEP = 0;
    localparam int MB_ADJRD   = 1;
    localparam int MB_STEPSGN = 2;
    localparam int MB_ADJSGN  = 3;
    localparam int MB_TOADJ   = 4;
    localparam int MB_IMMLO   = 5;
    localparam int MB_IMMFULL = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_IMM_MOD, ST_RD_AMOD, ST_RD_PMOD, ST_RD_WAIT
    } state_t;

    typedef enum logic [HA_W-1:0] {
        RA_DATA = 4'd0, RA_ADJDATA = 4'd1, RA_PTR0 = 4'd2, RA_PTR1 = 4'd3,
        RA_PTR2 = 4'd4, RA_ADJ0 = 4'd5, RA_ADJ1 = 4'd6, RA_STEP0 = 4'd7,
        RA_STEP1 = 4'd8, RA_MODE = 4'd9
    } regaddr_t;

    typedef struct packed {
        logic [PTR_W-1:0] rd_raw;
        logic [PTR_W-1:0] ptr_raw;
        logic             ptr_wr;
        logic [ADJ_W-1:0] adj_new;
        logic             adj_wr;
    } plan_t;
endpackage

// File: rtl/romport_modred.sv
`timescale 1ns/1ps
module romport_modred
    import romport_pkg::*;
#(
    parameter int W = PTR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] value,
    input  logic [W-1:0] modulus,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CW = $clog2(W);

    logic [W-1:0]   rem_q;
    logic [CW-1:0]  k_q;
    logic           run_q;
    logic [2*W-1:0] cand;

    assign cand   = {{W{1'b0}}, modulus} << k_q;
    assign result = rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            k_q   <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= value;
                k_q   <= CW'(W-1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cand <= {{W{1'b0}}, rem_q})
                    rem_q <= rem_q - cand[W-1:0];
                if (k_q == '0) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    k_q <= k_q - 1'b1;
                end
            end
        end
    end

    assert_mod_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && modulus != '0) |-> (result < modulus));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/romport_addrgen.sv
`timescale 1ns/1ps
module romport_addrgen
    import romport_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    input  logic [ADJ_W-1:0] adj,
    input  logic [ADJ_W-1:0] step,
    input  logic [7:0]       mode,
    input  logic             op_adj,
    input  logic [ADJ_W-1:0] imm_adj,
    output plan_t            plan,
    output logic [PTR_W-1:0] imm_raw
);
    localparam int XW = PTR_W - ADJ_W;
    localparam int LW = PTR_W - DAT_W;

    logic [PTR_W-1:0] adj_ext, step_ext, inc, imm_full, imm_lo;

    assign adj_ext  = {{XW{adj[ADJ_W-1] & mode[MB_ADJSGN]}}, adj};
    assign step_ext = {{XW{step[ADJ_W-1] & mode[MB_STEPSGN]}}, step};
    assign inc      = mode[MB_USESTEP] ? step_ext : PTR_W'(1);
    assign imm_full = {{XW{imm_adj[ADJ_W-1] & mode[MB_ADJSGN]}}, imm_adj};
    assign imm_lo   = {{LW{imm_adj[DAT_W-1] & mode[MB_ADJSGN]}}, imm_adj[DAT_W-1:0]};
    assign imm_raw  = ptr + (mode[MB_IMMFULL] ? imm_full : imm_lo);

    always_comb begin
        plan.rd_raw  = ptr + adj_ext;
        plan.ptr_raw = ptr;
        plan.ptr_wr  = 1'b0;
        plan.adj_new = adj;
        plan.adj_wr  = 1'b0;
        if (!op_adj) begin
            plan.ptr_wr = 1'b1;
            if (mode[MB_ADJRD]) begin
                plan.adj_new = adj + 1'b1;
                plan.adj_wr  = 1'b1;
            end else begin
                plan.rd_raw = ptr;
                if (!mode[MB_TOADJ]) begin
                    plan.ptr_raw = ptr + inc;
                end else begin
                    plan.adj_new = adj + inc[ADJ_W-1:0];
                    plan.adj_wr  = 1'b1;
                end
            end
        end else if (mode[MB_IMMLO] && mode[MB_IMMFULL]) begin
            if (!mode[MB_TOADJ]) begin
                plan.ptr_raw = ptr + adj_ext;
                plan.ptr_wr  = 1'b1;
            end else begin
                plan.adj_new = {adj[ADJ_W-2:0], 1'b0};
                plan.adj_wr  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/romport_top.sv
`timescale 1ns/1ps
module romport_top
    import romport_pkg::*;
#(
    parameter int ROM_AW    = 25,
    parameter int DATA_BASE = 24'h100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  rom_size,
    input  logic              hb_sel,
    input  logic              hb_we,
    input  logic [HA_W-1:0]   hb_addr,
    input  logic [DAT_W-1:0]  hb_wdata,
    output logic [DAT_W-1:0]  hb_rdata,
    output logic              hb_ready,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic              rom_valid,
    input  logic [DAT_W-1:0]  rom_data
);
    state_t state_q, state_d;

    logic [PTR_W-1:0]  ptr_q, rd_addr_q, newptr_q;
    logic [ADJ_W-1:0]  adj_q, step_q, imm_adj;
    logic [7:0]        mode_q;
    logic [MASK_W-1:0] wmask_q;
    logic [1:0]        trk_q, trk_nx;
    logic              op_adj_q, op_sel;

    logic acc, wr_acc, rd_acc, start_read, imm_mode, adj_wr_hit, imm_fire;
    logic gate_plain, gate_adj;
    logic             red_start, red_done;
    logic [PTR_W-1:0] red_val, red_res, imm_raw;
    plan_t            plan;

    // host decode
    assign acc        = hb_sel && (state_q == ST_IDLE);
    assign wr_acc     = acc && hb_we;
    assign rd_acc     = acc && !hb_we;
    assign gate_plain = &wmask_q[2:0];
    assign gate_adj   = &wmask_q;
    assign start_read = rd_acc && (((hb_addr == RA_DATA) && gate_plain) ||
                                   ((hb_addr == RA_ADJDATA) && gate_adj));
    assign imm_mode   = mode_q[MB_ADJRD] && (mode_q[MB_IMMLO] ^ mode_q[MB_IMMFULL]);
    assign adj_wr_hit = wr_acc && ((hb_addr == RA_ADJ0) || (hb_addr == RA_ADJ1));
    assign trk_nx     = trk_q | ((hb_addr == RA_ADJ0) ? 2'b01 : 2'b10);
    assign imm_fire   = adj_wr_hit && imm_mode && !mode_q[MB_TOADJ] && (trk_nx == 2'b11);
    assign imm_adj    = (hb_addr == RA_ADJ0) ? {adj_q[ADJ_W-1:DAT_W], hb_wdata}
                                             : {hb_wdata, adj_q[DAT_W-1:0]};
    assign op_sel     = (state_q == ST_IDLE) ? (hb_addr == RA_ADJDATA) : op_adj_q;

    romport_addrgen u_gen (
        .ptr(ptr_q), .adj(adj_q), .step(step_q), .mode(mode_q),
        .op_adj(op_sel), .imm_adj(imm_adj), .plan(plan), .imm_raw(imm_raw)
    );

    romport_modred #(.W(PTR_W)) u_red (
        .clk(clk), .rst_n(rst_n), .start(red_start), .value(red_val),
        .modulus(rom_size), .done(red_done), .result(red_res)
    );

    // reducer launch
    always_comb begin
        red_start = 1'b0;
        red_val   = plan.rd_raw;
        if (state_q == ST_IDLE && start_read) begin
            red_start = 1'b1;
        end else if (state_q == ST_IDLE && imm_fire) begin
            red_start = 1'b1;
            red_val   = imm_raw;
        end else if (state_q == ST_RD_AMOD && red_done && plan.ptr_wr) begin
            red_start = 1'b1;
            red_val   = plan.ptr_raw;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_read) state_d = ST_RD_AMOD;
                        else if (imm_fire) state_d = ST_IMM_MOD;
            ST_IMM_MOD: if (red_done) state_d = ST_IDLE;
            ST_RD_AMOD: if (red_done) state_d = plan.ptr_wr ? ST_RD_PMOD : ST_RD_WAIT;
            ST_RD_PMOD: if (red_done) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (rom_valid) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        hb_ready = 1'b0;
        hb_rdata = '0;
        rom_req  = 1'b0;
        rom_addr = ROM_AW'(DATA_BASE) + ROM_AW'(rd_addr_q);
        unique case (state_q)
            ST_IDLE: begin
                hb_ready = !start_read;
                case (hb_addr)
                    RA_PTR0:  hb_rdata = ptr_q[7:0];
                    RA_PTR1:  hb_rdata = ptr_q[15:8];
                    RA_PTR2:  hb_rdata = ptr_q[23:16];
                    RA_ADJ0:  hb_rdata = adj_q[7:0];
                    RA_ADJ1:  hb_rdata = adj_q[15:8];
                    RA_STEP0: hb_rdata = step_q[7:0];
                    RA_STEP1: hb_rdata = step_q[15:8];
                    RA_MODE:  hb_rdata = mode_q;
                    default:  hb_rdata = '0;
                endcase
            end
            ST_RD_WAIT: begin
                rom_req  = 1'b1;
                hb_ready = rom_valid;
                hb_rdata = rom_data;
            end
            default: ;
        endcase
    end

    // register file and datapath state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            adj_q     <= '0;
            step_q    <= '0;
            mode_q    <= '0;
            wmask_q   <= '0;
            trk_q     <= '0;
            op_adj_q  <= 1'b0;
            rd_addr_q <= '0;
            newptr_q  <= '0;
        end else begin
            if (wr_acc) begin
                case (hb_addr)
                    RA_PTR0:  begin ptr_q[7:0]   <= hb_wdata; wmask_q[0] <= 1'b1; end
                    RA_PTR1:  begin ptr_q[15:8]  <= hb_wdata; wmask_q[1] <= 1'b1; end
                    RA_PTR2:  begin ptr_q[23:16] <= hb_wdata; wmask_q[2] <= 1'b1; end
                    RA_ADJ0:  begin
                        adj_q[7:0] <= hb_wdata; wmask_q[3] <= 1'b1;
                        if (imm_mode) trk_q <= trk_nx;
                    end
                    RA_ADJ1:  begin
                        adj_q[15:8] <= hb_wdata; wmask_q[4] <= 1'b1;
                        if (imm_mode) trk_q <= trk_nx;
                    end
                    RA_STEP0: step_q[7:0]  <= hb_wdata;
                    RA_STEP1: step_q[15:8] <= hb_wdata;
                    RA_MODE:  if (&wmask_q[4:3]) begin
                        mode_q <= hb_wdata;
                        trk_q  <= '0;
                    end
                    default: ;
                endcase
            end
            if (start_read) op_adj_q <= (hb_addr == RA_ADJDATA);
            if (state_q == ST_IMM_MOD && red_done) ptr_q     <= red_res;
            if (state_q == ST_RD_AMOD && red_done) rd_addr_q <= red_res;
            if (state_q == ST_RD_PMOD && red_done) newptr_q  <= red_res;
            if (state_q == ST_RD_WAIT && rom_valid) begin
                if (plan.ptr_wr) ptr_q <= newptr_q;
                if (plan.adj_wr) adj_q <= plan.adj_new;
            end
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !rom_valid) |=> (rom_req && $stable(rom_addr)));

    assert_busy_notready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !rom_valid) |-> !hb_ready);

    assert_rom_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> ((rom_addr >= ROM_AW'(DATA_BASE)) &&
                     ({1'b0, rom_addr} < (ROM_AW+1)'(DATA_BASE) + (ROM_AW+1)'(rom_size))));

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> (&wmask_q[2:0]));

    assert_mode_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(wmask_q[4:3]) == 2'b11));

    assert_trk_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q != 2'b00) |-> (mode_q[MB_ADJRD] && (mode_q[MB_IMMLO] ^ mode_q[MB_IMMFULL])));
endmodule

// File: tb/romport_top_test.sv
`timescale 1ns/1ps
module romport_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] rom_size = 24'd1000;
    logic        hb_sel = 1'b0, hb_we = 1'b0;
    logic [3:0]  hb_addr = '0;
    logic [7:0]  hb_wdata = '0;
    logic [7:0]  hb_rdata;
    logic        hb_ready, rom_req, rom_valid = 1'b0;
    logic [24:0] rom_addr;
    logic [7:0]  rom_data = '0;
    logic [2:0]  rcnt = '0;

    int nchk = 0, nfail = 0;
    longint m_ptr, m_adj, m_step, m_mode, m_wm, m_trk;
    logic [7:0] d;
    int waits;

    always #2 clk = ~clk;

    romport_top uut (
        .clk(clk), .rst_n(rst_n), .rom_size(rom_size), .hb_sel(hb_sel), .hb_we(hb_we),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ready(hb_ready),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid), .rom_data(rom_data)
    );

    function automatic logic [7:0] rbyte(longint a);
        return 8'((a ^ (a >> 8) ^ (a >> 16) ^ 8'h5A) & 8'hFF);
    endfunction

    always @(posedge clk) begin
        if (rom_req && !rom_valid) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == 3'd2) begin
                rom_valid <= 1'b1;
                rom_data  <= rbyte(longint'(rom_addr));
            end
        end else begin
            rom_valid <= 1'b0;
            rcnt      <= '0;
        end
    end

    task automatic chk(string rq, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic longint red(longint v);
        return (v & 64'hFFFFFF) % longint'(rom_size);
    endfunction

    function automatic longint sx16(longint v, longint s);
        return (s != 0) ? ((v ^ 64'h8000) - 64'h8000) : v;
    endfunction

    function automatic longint sx8(longint v, longint s);
        return (s != 0) ? ((v ^ 64'h80) - 64'h80) : v;
    endfunction

    task automatic bus(input logic we, input logic [3:0] a, input logic [7:0] wd,
                       output logic [7:0] rd, output int w);
        @(negedge clk);
        hb_sel = 1'b1; hb_we = we; hb_addr = a; hb_wdata = wd; w = 0;
        #1;
        while (!hb_ready) begin
            @(negedge clk); #1; w++;
        end
        rd = hb_rdata;
        @(negedge clk);
        hb_sel = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        logic [7:0] dd; int ww;
        longint b5, b6;
        bus(1'b1, a, v, dd, ww);
        b5 = (m_mode >> 5) & 1; b6 = (m_mode >> 6) & 1;
        case (a)
            4'd2: begin m_ptr = (m_ptr & ~64'hFF)     | v;         m_wm |= 1; end
            4'd3: begin m_ptr = (m_ptr & ~64'hFF00)   | (v << 8);  m_wm |= 2; end
            4'd4: begin m_ptr = (m_ptr & ~64'hFF0000) | (v << 16); m_wm |= 4; end
            4'd5, 4'd6: begin
                if (a == 4'd5) begin m_adj = (m_adj & 64'hFF00) | v; m_wm |= 8; end
                else begin m_adj = (m_adj & 64'hFF) | (v << 8); m_wm |= 16; end
                if (((m_mode >> 1) & 1) != 0 && (b5 ^ b6) != 0) begin
                    m_trk |= (a == 4'd5) ? 1 : 2;
                    if (m_trk == 3 && ((m_mode >> 4) & 1) == 0)
                        m_ptr = red(m_ptr + ((b6 != 0) ? sx16(m_adj, (m_mode >> 3) & 1)
                                                      : sx8(m_adj & 64'hFF, (m_mode >> 3) & 1)));
                end
            end
            4'd7: m_step = (m_step & 64'hFF00) | v;
            4'd8: m_step = (m_step & 64'hFF) | (v << 8);
            4'd9: if ((m_wm & 24) == 24) begin m_mode = v; m_trk = 0; end
            default: ;
        endcase
    endtask

    task automatic chk_regs(string rq);
        logic [7:0] b0, b1, b2; int ww;
        bus(1'b0, 4'd2, 8'h0, b0, ww);
        bus(1'b0, 4'd3, 8'h0, b1, ww);
        bus(1'b0, 4'd4, 8'h0, b2, ww);
        chk({rq, " pointer"}, longint'({b2, b1, b0}), m_ptr);
        bus(1'b0, 4'd5, 8'h0, b0, ww);
        bus(1'b0, 4'd6, 8'h0, b1, ww);
        chk({rq, " adjust"}, longint'({b1, b0}), m_adj);
    endtask

    // port read against the requirement model
    task automatic rd_port(input logic adjp, string rq);
        longint ax, ra, inc, exp;
        logic [7:0] dd; int ww;
        bus(1'b0, adjp ? 4'd1 : 4'd0, 8'h0, dd, ww);
        if ((!adjp && (m_wm & 7) != 7) || (adjp && m_wm != 31)) begin
            chk("R2 gated data", longint'(dd), 0);
            chk("R2 gated no wait", ww, 0);
            return;
        end
        ax = sx16(m_adj, (m_mode >> 3) & 1);
        if (!adjp) begin
            if (((m_mode >> 1) & 1) != 0) begin
                ra = red(m_ptr + ax);
                m_adj = (m_adj + 1) & 64'hFFFF;
                m_ptr = red(m_ptr);
            end else begin
                ra  = red(m_ptr);
                inc = ((m_mode & 1) != 0) ? sx16(m_step, (m_mode >> 2) & 1) : 1;
                if (((m_mode >> 4) & 1) == 0) m_ptr = red(m_ptr + inc);
                else begin m_adj = (m_adj + inc) & 64'hFFFF; m_ptr = red(m_ptr); end
            end
        end else begin
            ra = red(m_ptr + ax);
            if (((m_mode >> 5) & 3) == 3) begin
                if (((m_mode >> 4) & 1) == 0) m_ptr = red(m_ptr + ax);
                else m_adj = (m_adj * 2) & 64'hFFFF;
            end
        end
        exp = longint'(rbyte(64'h100000 + ra));
        chk(rq, longint'(dd), exp);
        chk("R10 busy wait", longint'(ww > 24), 1);
    endtask

    initial begin
        int ww;
        m_ptr = 0; m_adj = 0; m_step = 0; m_mode = 0; m_wm = 0; m_trk = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 ready idle", longint'(hb_ready), 1);
        chk("R1 no request", longint'(rom_req), 0);
        for (int a = 2; a <= 9; a++) begin
            bus(1'b0, 4'(a), 8'h0, d, ww);
            chk("R1 reset register", longint'(d), 0);
        end
        bus(1'b0, 4'd12, 8'h0, d, ww);
        chk("R1 unused offset", longint'(d), 0);
        // R2: gating by written mask
        rd_port(1'b0, "R2");
        wr(4'd2, 8'hE6); wr(4'd3, 8'h03);
        rd_port(1'b0, "R2");
        wr(4'd4, 8'h00);
        rd_port(1'b1, "R2");
        // R3: mode write ignored before both adjust bytes
        wr(4'd5, 8'h00);
        wr(4'd9, 8'h01);
        bus(1'b0, 4'd9, 8'h0, d, ww);
        chk("R3 mode ignored", longint'(d), 0);
        wr(4'd6, 8'h00);
        // R6 R7: stream across the wrap (pointer 998, size 1000)
        for (int i = 0; i < 4; i++) begin
            rd_port(1'b0, "R6 R7 stream");
            chk_regs("R7");
        end
        wr(4'd7, 8'hFD); wr(4'd8, 8'hFF);
        wr(4'd9, 8'h05);
        bus(1'b0, 4'd9, 8'h0, d, ww);
        chk("R3 mode accepted", longint'(d), 5);
        rd_port(1'b0, "R6 signed step");
        chk_regs("R6");
        // sweep all mode values under two ROM sizes
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            rom_size = (s == 0) ? 24'd1000 : 24'hF00003;
            for (int m = 0; m < 128; m++) begin
                longint p, aj, st;
                p  = (longint'(m) * 7919 + 123 + s * 64'h7FF000) & 64'hFFFFFF;
                aj = (longint'(m) * 40503 + s * 64'h8000) & 64'hFFFF;
                st = ((longint'(m) * 1237) ^ 64'h8001) & 64'hFFFF;
                wr(4'd9, 8'(m));
                bus(1'b0, 4'd9, 8'h0, d, ww);
                chk("R3 mode readback", longint'(d), m_mode);
                wr(4'd2, 8'(p)); wr(4'd3, 8'(p >> 8)); wr(4'd4, 8'(p >> 16));
                wr(4'd7, 8'(st)); wr(4'd8, 8'(st >> 8));
                wr(4'd5, 8'(aj)); wr(4'd6, 8'(aj >> 8));
                chk_regs("R9 immediate");
                rd_port(1'b0, "R4 R5 R6 plain read");
                chk_regs("R5 R6 R7 plain update");
                rd_port(1'b1, "R8 adjusted read");
                chk_regs("R8 adjusted update");
            end
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R10 watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule